// File: doc/BRIEF.md
# Flash Password Register Controller

This block holds the 64-bit password of a flash command interface and decodes the bus write cycles that program it or read it back. Software reaches it only through write cycles (address plus 16-bit data) and through a read port. A program operation is a two-cycle unlock prefix, a program command code, and one data cycle. The data cycle writes one 16-bit quarter of the password, picked by the low two address bits. Cells can only be cleared. The stored word becomes the AND of the old and new data, and any attempt to raise a cleared bit sets a timeout flag.

After a data cycle the block stays busy for a fixed, parameterized number of clock cycles. During that time reads return a status word instead of data. When the busy time ends, the status stays visible until a read/reset write returns the interface to normal mode. A second command code enters a verify mode in which the read port returns the selected password quarter. An input from the mode-lock logic forces those verify reads to all ones. A two-write exit sequence leaves verify mode.

Top module: `pwd_reg_ctrl`

## Requirements
- R1: After reset all four password words read FFFFh through verify mode, busy and pgm_timeout are 0, and rd_data in normal mode is 0000h.
- R2: The writes AAh@555h, 55h@2AAh, 38h@555h, then data D at address A update password word A[1:0] to old & D. Only data bits [7:0] are compared on command cycles. Words may be written in any order.
- R3: A program cycle whose data has a 1 where the stored word has a 0 leaves that bit 0 and raises pgm_timeout together with busy. The flag stays set until the read/reset write. No stored bit ever goes from 0 to 1.
- R4: busy is high for exactly BUSY_CYC clock cycles after the data cycle. Writes made while busy change neither the password nor the command state.
- R5: Reads while busy return a status word with bit 7 = NOT D[7], bit 5 = the timeout flag and all other bits 0. After busy ends, reads return the same word but with bit 7 = D[7].
- R6: In the post-program state a write with data[7:0] = F0h returns to normal mode, which reads 0000h and clears pgm_timeout. Other writes in that state are ignored.
- R7: A wrong address or data on any unlock or command cycle returns the decoder to idle. No password bit changes, and a following lone data write does not program.
- R8: AAh@555h, 55h@2AAh, C8h@555h enters verify mode. There rd_data (one cycle after rd_addr) returns password word rd_addr[1:0], and upper address bits are ignored.
- R9: In verify mode with mode_locked high, rd_data is FFFFh whatever the stored word.
- R10: In verify mode, a write of 90h followed by a write of 00h returns to normal mode. Other writes leave verify mode active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read address |
| mode_locked | input | 1 | Password mode lock; forces verify reads to ones |
| rd_data | output | 16 | Registered read data |
| busy | output | 1 | Program operation in progress |
| pgm_timeout | output | 1 | Illegal 0-to-1 program attempt seen |

## Verification
The properties assume that wr_en is a single-cycle strobe and that mode_locked changes only between operations, never in the cycle a verify read is captured. The stimulus applies every write as one-cycle pulses placed between clock edges. It keeps mode_locked constant for the whole of each verify session. Random program data is drawn mostly as subsets of the stored word, with occasional free values that provoke the timeout path. Broken unlock sequences and writes during busy are mixed in to show they are ignored.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PDATA, S_BUSY, S_DONE, S_VFY, S_VFYX
  } cmd_state_t;

  localparam logic [7:0] KEY1     = 8'hAA;
  localparam logic [7:0] KEY2     = 8'h55;
  localparam logic [7:0] OP_PGM   = 8'h38;
  localparam logic [7:0] OP_VFY   = 8'hC8;
  localparam logic [7:0] OP_RST   = 8'hF0;
  localparam logic [7:0] OP_EXIT1 = 8'h90;
  localparam logic [7:0] OP_EXIT2 = 8'h00;
  localparam logic [11:0] KEY_ADDR1 = 12'h555;
  localparam logic [11:0] KEY_ADDR2 = 12'h2AA;
endpackage

// File: rtl/pwd_cmd_fsm.sv
module pwd_cmd_fsm
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_cmd,
  output cmd_state_t        state,
  output logic              pgm_fire,
  output logic              rr_fire
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY_ADDR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY_ADDR2);

  logic [CNT_W-1:0] cnt;

  assign pgm_fire = (state == S_PDATA) && wr_en;
  assign rr_fire  = (state == S_DONE) && wr_en && (wr_cmd == OP_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (wr_en && wr_addr == A1 && wr_cmd == KEY1) state <= S_UNL1;
        S_UNL1:
          if (wr_en) state <= (wr_addr == A2 && wr_cmd == KEY2) ? S_UNL2 : S_IDLE;
        S_UNL2:
          if (wr_en) begin
            if (wr_addr == A1 && wr_cmd == OP_PGM)      state <= S_PDATA;
            else if (wr_addr == A1 && wr_cmd == OP_VFY) state <= S_VFY;
            else                                        state <= S_IDLE;
          end
        S_PDATA:
          if (wr_en) begin
            state <= S_BUSY;
            cnt   <= CNT_W'(BUSY_CYC - 1);
          end
        S_BUSY:
          if (cnt == '0) state <= S_DONE;
          else           cnt   <= cnt - 1'b1;
        S_DONE:
          if (rr_fire) state <= S_IDLE;
        S_VFY:
          if (wr_en && wr_cmd == OP_EXIT1) state <= S_VFYX;
        S_VFYX:
          if (wr_en) state <= (wr_cmd == OP_EXIT2) ? S_IDLE : S_VFY;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwd_store.sv
module pwd_store #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [SEL_W-1:0]        waddr,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [SEL_W-1:0]        raddr,
  output logic [WORD_W-1:0]       rdata,
  output logic                    viol,
  output logic [WORD_W*WORDS-1:0] flat
);
  logic [WORD_W-1:0] mem [WORDS];

  assign rdata = mem[raddr];
  assign viol  = |(wdata & ~mem[waddr]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= mem[waddr] & wdata;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign flat[g*WORD_W +: WORD_W] = mem[g];
  end
endmodule

// File: rtl/pwd_rd_path.sv
module pwd_rd_path
  import pwd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_state_t        state,
  input  logic [WORD_W-1:0] pw_word,
  input  logic              locked,
  input  logic              d7_q,
  input  logic              tmo_q,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] stat_busy, stat_done;

  always_comb begin
    stat_busy    = '0;
    stat_busy[7] = ~d7_q;
    stat_busy[5] = tmo_q;
    stat_done    = stat_busy;
    stat_done[7] = d7_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (state)
        S_BUSY:         rd_data <= stat_busy;
        S_DONE:         rd_data <= stat_done;
        S_VFY, S_VFYX:  rd_data <= locked ? '1 : pw_word;
        default:        rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pwd_reg_ctrl.sv
module pwd_reg_ctrl
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 16,
  parameter int WORDS    = 4,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              mode_locked,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              pgm_timeout
);
  localparam int SEL_W = $clog2(WORDS);
  localparam int PW_W  = WORD_W * WORDS;

  cmd_state_t        state;
  logic              pgm_fire, rr_fire, viol, d7_q, tmo_q, vfy_active;
  logic [WORD_W-1:0] pw_word;
  logic [PW_W-1:0]   pw_flat;

  pwd_cmd_fsm #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_cmd(wr_data[7:0]), .state(state), .pgm_fire(pgm_fire), .rr_fire(rr_fire)
  );

  pwd_store #(.WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk(clk), .rst(rst), .we(pgm_fire), .waddr(wr_addr[SEL_W-1:0]),
    .wdata(wr_data), .raddr(rd_addr[SEL_W-1:0]), .rdata(pw_word),
    .viol(viol), .flat(pw_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      d7_q  <= 1'b0;
      tmo_q <= 1'b0;
    end else if (pgm_fire) begin
      d7_q  <= wr_data[7];
      tmo_q <= viol;
    end else if (rr_fire) begin
      tmo_q <= 1'b0;
    end
  end

  pwd_rd_path #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .state(state), .pw_word(pw_word),
    .locked(mode_locked), .d7_q(d7_q), .tmo_q(tmo_q), .rd_data(rd_data)
  );

  assign busy        = (state == S_BUSY);
  assign pgm_timeout = tmo_q;
  assign vfy_active  = (state == S_VFY) || (state == S_VFYX);
endmodule

// File: rtl/pwd_reg_ctrl_chk.sv
module pwd_reg_ctrl_chk #(
  parameter int WORD_W = 16,
  parameter int PW_W   = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              busy,
  input logic              pgm_timeout,
  input logic              mode_locked,
  input logic              vfy_active,
  input logic [WORD_W-1:0] rd_data,
  input logic [PW_W-1:0]   pw_flat
);
  // R3
  zero_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pw_flat & ~$past(pw_flat)) == '0));

  // R3
  tmo_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pgm_timeout) |-> busy);

  // R4
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> $stable(pw_flat));

  // R5
  busy_status_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (rd_data[WORD_W-1:8] == '0));

  // R9
  lock_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (vfy_active && mode_locked) |=> (rd_data == '1));
endmodule

bind pwd_reg_ctrl pwd_reg_ctrl_chk #(.WORD_W(WORD_W), .PW_W(PW_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .pgm_timeout(pgm_timeout),
  .mode_locked(mode_locked), .vfy_active(vfy_active), .rd_data(rd_data),
  .pw_flat(pw_flat)
);

// File: tb/tb_pwd_reg_ctrl.sv
`timescale 1ns/1ps
module tb_pwd_reg_ctrl;
  localparam int ADDR_W = 12;
  localparam int BUSY_CYC = 8;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, mode_locked = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic busy, pgm_timeout;
  logic [15:0] pw_m [4];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwd_reg_ctrl #(.ADDR_W(ADDR_W), .WORD_W(16), .WORDS(4), .BUSY_CYC(BUSY_CYC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .mode_locked(mode_locked), .rd_data(rd_data),
    .busy(busy), .pgm_timeout(pgm_timeout)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_word(logic b7, logic tmo);
    logic [15:0] s = '0;
    s[7] = b7; s[5] = tmo;
    return s;
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  // R2 R3 R4 R5 R6: full program operation
  task automatic program_word(logic [1:0] w, logic [15:0] d);
    logic viol;
    int n;
    viol = |(d & ~pw_m[w]);
    unlock();
    wr(12'h555, 16'h0038);
    wr({ADDR_W'($urandom_range(0, 1023)) << 2} | ADDR_W'(w), d);
    pw_m[w] = pw_m[w] & d;
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      if (n == 1) begin
        chk("R5 busy status", rd_data, stat_word(~d[7], viol));
        chk("R3 timeout while busy", {15'h0, pgm_timeout}, {15'h0, viol});
      end
      n++;
      @(negedge clk);
    end
    chk("R4 busy length", 16'(n), 16'(BUSY_CYC));
    @(negedge clk);
    chk("R5 done status", rd_data, stat_word(d[7], viol));
    wr(12'h123, 16'h0012);
    chk("R6 ignored write in done", rd_data, stat_word(d[7], viol));
    wr(12'h000, 16'h00F0);
    @(negedge clk);
    chk("R6 normal read", rd_data, 16'h0000);
    chk("R6 timeout cleared", {15'h0, pgm_timeout}, 16'h0);
  endtask

  // R8 R9 R10: verify all words
  task automatic verify_all(logic lk, string tag);
    unlock();
    wr(12'h555, 16'h00C8);
    mode_locked = lk;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      rd_addr = (ADDR_W'($urandom_range(0, 1023)) << 2) | ADDR_W'(w);
      @(negedge clk);
      chk(tag, rd_data, lk ? 16'hFFFF : pw_m[w]);
    end
    wr(12'h000, 16'h0090);
    wr(12'h000, 16'h0011);
    @(negedge clk);
    chk("R10 still verifying after bad exit", rd_data, lk ? 16'hFFFF : pw_m[rd_addr[1:0]]);
    wr(12'h000, 16'h0090);
    wr(12'h000, 16'h0000);
    @(negedge clk);
    mode_locked = 1'b0;
    chk("R10 exit to normal", rd_data, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) pw_m[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 16'h0000);
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 timeout", {15'h0, pgm_timeout}, 16'h0);
    verify_all(1'b0, "R1 R8 reset password");

    // R2 directed, out-of-order words
    program_word(2'd3, 16'h1234);
    program_word(2'd0, 16'h8F0F);
    // R3 set a cleared bit
    program_word(2'd3, 16'h1235);
    verify_all(1'b0, "R2 R3 directed verify");

    // R7 bad unlock address, bad key, bad command
    wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h001, 16'h0000);
    @(negedge clk);
    chk("R7 bad address no busy", {15'h0, busy}, 16'h0);
    wr(12'h555, 16'h00AB); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0038);
    wr(12'h002, 16'h0000);
    @(negedge clk);
    chk("R7 bad key no busy", {15'h0, busy}, 16'h0);
    unlock(); wr(12'h555, 16'h0037); wr(12'h001, 16'h0000);
    @(negedge clk);
    chk("R7 bad command no busy", {15'h0, busy}, 16'h0);
    verify_all(1'b0, "R7 password unchanged");

    // R4 write during busy is ignored
    unlock(); wr(12'h555, 16'h0038); wr(12'h001, 16'hFF00);
    pw_m[1] = pw_m[1] & 16'hFF00;
    wr(12'h002, 16'h0000);
    while (busy === 1'b1) @(negedge clk);
    wr(12'h000, 16'h00F0);
    verify_all(1'b0, "R4 busy write ignored");

    // R9 locked verify
    verify_all(1'b1, "R9 locked reads ones");

    // random programs
    for (int it = 0; it < 40; it++) begin
      logic [1:0] w;
      logic [15:0] d;
      w = 2'($urandom_range(0, 3));
      d = ($urandom_range(0, 3) == 0) ? 16'($urandom) : (pw_m[w] | 16'($urandom)) & 16'($urandom) | ~pw_m[w] & 16'h0;
      if (($urandom_range(0, 3)) != 0) d = pw_m[w] & 16'($urandom) | (pw_m[w] & 16'h0);
      program_word(w, d);
      if (it % 10 == 9) verify_all(1'b0, "R2 R8 random verify");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end
endmodule